// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath that shares one ALU and one memory across cycles. It holds an explicit 4-bit state register and, from the 6-bit opcode held in the datapath's instruction register, steps each instruction through three to five cycles. Each state drives a fixed set of one-bit enables and mux selects, a 2-bit ALU operation class and a 2-bit PC source select. The outputs are a function of the current state only.

Every instruction begins with the same two states. `ST_FETCH` reads memory at PC into the instruction register and writes PC+4 into PC. `ST_DECODE` lets the datapath latch the source registers and precompute a branch target in ALUOut. After that the path splits by instruction class:
- loads run `ST_MEM_ADDR` → `ST_LOAD_READ` → `ST_LOAD_WB` (five cycles in total);
- stores run `ST_MEM_ADDR` → `ST_STORE_WRITE` (four cycles);
- register arithmetic runs `ST_ALU_EXEC` → `ST_ALU_WB` (four cycles);
- branches finish in `ST_BRANCH` and jumps finish in `ST_JUMP` (three cycles each).

An opcode the block does not recognise sends `ST_DECODE` straight back to `ST_FETCH`. The last state of every path also returns to `ST_FETCH`. A write enable asserted in a cycle takes effect at the clock edge that ends that cycle.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high, every output is 0. `rst` is sampled synchronously and places the machine in the fetch state, so the first cycle after `rst` falls shows the fetch outputs.
- R2: Fetch asserts `pc_we`, `mem_rd` and `ir_we`, with `alu_b_sel`=01, `alu_class`=00, `pc_sel`=00, `addr_is_data`=0 and `alu_a_sel`=0. The decode cycle follows, for every opcode.
- R3: Decode asserts no enable and drives `alu_b_sel`=11, `alu_a_sel`=0 and `alu_class`=00.
- R4: Load (opcode 100011) takes five cycles. Third cycle: `alu_a_sel`=1, `alu_b_sel`=10, `alu_class`=00. Fourth cycle: `mem_rd`=1 with `addr_is_data`=1. Fifth cycle: `rf_we`=1, `wb_from_mem`=1, `dst_is_rd`=0.
- R5: Store (opcode 101011) takes four cycles. The third cycle matches the load's third cycle. The fourth cycle asserts `mem_wr`=1 with `addr_is_data`=1.
- R6: Register arithmetic (opcode 000000) takes four cycles. Third cycle: `alu_a_sel`=1, `alu_b_sel`=00, `alu_class`=10. Fourth cycle: `rf_we`=1, `dst_is_rd`=1, `wb_from_mem`=0.
- R7: Branch (opcode 000100) takes three cycles. The third cycle asserts `pc_we_cond`=1 with `pc_sel`=01, `alu_class`=01, `alu_a_sel`=1 and `alu_b_sel`=00, and `pc_we`=0.
- R8: Jump (opcode 000010) takes three cycles. The third cycle asserts `pc_we`=1 with `pc_sel`=10.
- R9: Any other opcode spends two cycles (fetch, decode) and then fetches again.
- R10: Outputs depend only on the state. Changing `opcode` within a cycle leaves every output unchanged.
- R11: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write qualified by the datapath's equality result |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register load |
| rf_we | output | 1 | Register file write |
| addr_is_data | output | 1 | Memory address from ALUOut (1) or PC (0) |
| dst_is_rd | output | 1 | Destination register from bits 15:11 (1) or 20:16 (0) |
| wb_from_mem | output | 1 | Write-back data from the data register (1) or ALUOut (0) |
| alu_a_sel | output | 1 | ALU A operand: register A (1) or PC (0) |
| alu_b_sel | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 extended offset, 11 offset shifted by 2 |
| alu_class | output | 2 | ALU class: 00 add, 01 subtract/compare, 10 from function code |
| pc_sel | output | 2 | PC source: 00 ALU result, 01 ALUOut, 10 jump target |

## Verification
Each of the five recognised opcodes is held through a complete instruction, and so is one unrecognised opcode. Each per-cycle control word is compared against its expected value, so a wrong sequence length, a wrong branch in the next-state logic or a wrong output in a single state each give a distinct mismatch.

An opcode that changes partway through the fetch cycle shows whether the outputs leak from the input. That would be a Mealy fault, which cannot be seen while the opcode is held steady. A reset asserted in the middle of a load shows that the enables are silenced at once and that the machine restarts at fetch rather than resuming.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    typedef enum logic [3:0] {
        ST_FETCH       = 4'd0,
        ST_DECODE      = 4'd1,
        ST_MEM_ADDR    = 4'd2,
        ST_LOAD_READ   = 4'd3,
        ST_LOAD_WB     = 4'd4,
        ST_STORE_WRITE = 4'd5,
        ST_ALU_EXEC    = 4'd6,
        ST_ALU_WB      = 4'd7,
        ST_BRANCH      = 4'd8,
        ST_JUMP        = 4'd9
    } state_e;

    typedef enum logic [2:0] {
        IC_ALU     = 3'd0,
        IC_LOAD    = 3'd1,
        IC_STORE   = 3'd2,
        IC_BRANCH  = 3'd3,
        IC_JUMP    = 3'd4,
        IC_UNKNOWN = 3'd5
    } instr_class_e;

    localparam int unsigned SEL_W = 2;

    typedef struct packed {
        logic             pc_we;
        logic             pc_we_cond;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_we;
        logic             rf_we;
        logic             addr_is_data;
        logic             dst_is_rd;
        logic             wb_from_mem;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_class;
        logic [SEL_W-1:0] pc_sel;
    } ctrl_t;

endpackage

// File: rtl/mcf_op_classify.sv
module mcf_op_classify
    import mcf_pkg::*;
#(
    parameter int unsigned          OP_W      = 6,
    parameter logic [OP_W-1:0]      OP_ALU    = 6'b000000,
    parameter logic [OP_W-1:0]      OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0]      OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0]      OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0]      OP_JUMP   = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output instr_class_e    iclass
);

    always_comb begin
        if      (opcode == OP_ALU)    iclass = IC_ALU;
        else if (opcode == OP_LOAD)   iclass = IC_LOAD;
        else if (opcode == OP_STORE)  iclass = IC_STORE;
        else if (opcode == OP_BRANCH) iclass = IC_BRANCH;
        else if (opcode == OP_JUMP)   iclass = IC_JUMP;
        else                          iclass = IC_UNKNOWN;
    end

endmodule

// File: rtl/mcf_next_state.sv
module mcf_next_state
    import mcf_pkg::*;
(
    input  state_e       state,
    input  instr_class_e iclass,
    output state_e       state_nx
);

    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_FETCH: state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (iclass)
                    IC_LOAD, IC_STORE: state_nx = ST_MEM_ADDR;
                    IC_ALU:            state_nx = ST_ALU_EXEC;
                    IC_BRANCH:         state_nx = ST_BRANCH;
                    IC_JUMP:           state_nx = ST_JUMP;
                    default:           state_nx = ST_FETCH;
                endcase
            end
            ST_MEM_ADDR: begin
                // the held opcode picks the read or write leg
                if (iclass == IC_LOAD)       state_nx = ST_LOAD_READ;
                else if (iclass == IC_STORE) state_nx = ST_STORE_WRITE;
                else                         state_nx = ST_FETCH;
            end
            ST_LOAD_READ:   state_nx = ST_LOAD_WB;
            ST_LOAD_WB:     state_nx = ST_FETCH;
            ST_STORE_WRITE: state_nx = ST_FETCH;
            ST_ALU_EXEC:    state_nx = ST_ALU_WB;
            ST_ALU_WB:      state_nx = ST_FETCH;
            ST_BRANCH:      state_nx = ST_FETCH;
            ST_JUMP:        state_nx = ST_FETCH;
            default:        state_nx = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcf_ctrl_decode.sv
module mcf_ctrl_decode
    import mcf_pkg::*;
(
    input  state_e state,
    output ctrl_t  ctrl
);

    localparam logic [SEL_W-1:0] B_REG   = 2'b00;
    localparam logic [SEL_W-1:0] B_FOUR  = 2'b01;
    localparam logic [SEL_W-1:0] B_OFS   = 2'b10;
    localparam logic [SEL_W-1:0] B_OFS_2 = 2'b11;
    localparam logic [SEL_W-1:0] K_ADD   = 2'b00;
    localparam logic [SEL_W-1:0] K_SUB   = 2'b01;
    localparam logic [SEL_W-1:0] K_FUNCT = 2'b10;
    localparam logic [SEL_W-1:0] P_ALU   = 2'b00;
    localparam logic [SEL_W-1:0] P_OUT   = 2'b01;
    localparam logic [SEL_W-1:0] P_JMP   = 2'b10;

    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_we     = 1'b1;
                ctrl.pc_we     = 1'b1;
                ctrl.alu_b_sel = B_FOUR;
                ctrl.alu_class = K_ADD;
                ctrl.pc_sel    = P_ALU;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = B_OFS_2;
                ctrl.alu_class = K_ADD;
            end
            ST_MEM_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = B_OFS;
                ctrl.alu_class = K_ADD;
            end
            ST_LOAD_READ: begin
                ctrl.mem_rd       = 1'b1;
                ctrl.addr_is_data = 1'b1;
            end
            ST_LOAD_WB: begin
                ctrl.rf_we       = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            ST_STORE_WRITE: begin
                ctrl.mem_wr       = 1'b1;
                ctrl.addr_is_data = 1'b1;
            end
            ST_ALU_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = B_REG;
                ctrl.alu_class = K_FUNCT;
            end
            ST_ALU_WB: begin
                ctrl.rf_we     = 1'b1;
                ctrl.dst_is_rd = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = B_REG;
                ctrl.alu_class  = K_SUB;
                ctrl.pc_we_cond = 1'b1;
                ctrl.pc_sel     = P_OUT;
            end
            ST_JUMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_sel = P_JMP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcf_pkg::*;
#(
    parameter int unsigned OP_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic            pc_we,
    output logic            pc_we_cond,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_we,
    output logic            rf_we,
    output logic            addr_is_data,
    output logic            dst_is_rd,
    output logic            wb_from_mem,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_class,
    output logic [1:0]      pc_sel
);

    state_e       state_q;
    state_e       state_nx;
    instr_class_e iclass;
    ctrl_t        ctrl_s;
    ctrl_t        ctrl_o;

    mcf_op_classify #(.OP_W(OP_W)) u_classify (
        .opcode (opcode),
        .iclass (iclass)
    );

    mcf_next_state u_next (
        .state    (state_q),
        .iclass   (iclass),
        .state_nx (state_nx)
    );

    mcf_ctrl_decode u_decode (
        .state (state_q),
        .ctrl  (ctrl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_nx;
    end

    // reset silences every output, whatever the state register holds
    always_comb ctrl_o = rst ? '0 : ctrl_s;

    assign pc_we        = ctrl_o.pc_we;
    assign pc_we_cond   = ctrl_o.pc_we_cond;
    assign mem_rd       = ctrl_o.mem_rd;
    assign mem_wr       = ctrl_o.mem_wr;
    assign ir_we        = ctrl_o.ir_we;
    assign rf_we        = ctrl_o.rf_we;
    assign addr_is_data = ctrl_o.addr_is_data;
    assign dst_is_rd    = ctrl_o.dst_is_rd;
    assign wb_from_mem  = ctrl_o.wb_from_mem;
    assign alu_a_sel    = ctrl_o.alu_a_sel;
    assign alu_b_sel    = ctrl_o.alu_b_sel;
    assign alu_class    = ctrl_o.alu_class;
    assign pc_sel       = ctrl_o.pc_sel;

    // R1: no enable while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> !(pc_we || pc_we_cond || mem_wr || rf_we || ir_we || mem_rd));

    // R2: fetch is always followed by the decode cycle
    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (alu_b_sel == 2'b11 && !ir_we && !rf_we && !mem_wr && !pc_we));

    // R4: a load write-back comes straight after a data read
    a_r4_load_wb_after_read: assert property (@(posedge clk) disable iff (rst)
        (rf_we && wb_from_mem) |-> $past(mem_rd && addr_is_data));

    // R7: a branch ends the instruction
    a_r7_branch_ends: assert property (@(posedge clk) disable iff (rst)
        pc_we_cond |=> ir_we);

    // R8: a jump ends the instruction
    a_r8_jump_ends: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_sel == 2'b10) |=> ir_we);

    // R11: a single memory port is never asked to read and write at once
    a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

endmodule

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    // word layout: {pc_we, pc_we_cond, mem_rd, mem_wr, ir_we, rf_we, addr_is_data,
    //               dst_is_rd, wb_from_mem, alu_a_sel, alu_b_sel[1:0], alu_class[1:0], pc_sel[1:0]}
    localparam logic [15:0] W_FETCH  = 16'hA810; // R2
    localparam logic [15:0] W_DEC    = 16'h0030; // R3
    localparam logic [15:0] W_ADDR   = 16'h0060; // R4 R5
    localparam logic [15:0] W_LDRD   = 16'h2200; // R4
    localparam logic [15:0] W_LDWB   = 16'h0480; // R4
    localparam logic [15:0] W_STWR   = 16'h1200; // R5
    localparam logic [15:0] W_EXEC   = 16'h0048; // R6
    localparam logic [15:0] W_RWB    = 16'h0500; // R6
    localparam logic [15:0] W_BR     = 16'h4045; // R7
    localparam logic [15:0] W_JMP    = 16'h8002; // R8

    localparam logic [5:0] O_LW = 6'b100011, O_SW = 6'b101011, O_RT = 6'b000000,
                           O_BQ = 6'b000100, O_JP = 6'b000010, O_BAD = 6'b111011;

    // {requirement number, opcode, expected word}
    localparam logic [25:0] VEC [NVEC] = '{
        {4'd4, O_LW, W_FETCH}, {4'd4, O_LW, W_DEC}, {4'd4, O_LW, W_ADDR},
        {4'd4, O_LW, W_LDRD},  {4'd4, O_LW, W_LDWB},
        {4'd5, O_SW, W_FETCH}, {4'd5, O_SW, W_DEC}, {4'd5, O_SW, W_ADDR},
        {4'd5, O_SW, W_STWR},
        {4'd6, O_RT, W_FETCH}, {4'd6, O_RT, W_DEC}, {4'd6, O_RT, W_EXEC},
        {4'd6, O_RT, W_RWB},
        {4'd7, O_BQ, W_FETCH}, {4'd7, O_BQ, W_DEC}, {4'd7, O_BQ, W_BR},
        {4'd8, O_JP, W_FETCH}, {4'd8, O_JP, W_DEC}, {4'd8, O_JP, W_JMP},
        {4'd9, O_BAD, W_FETCH}, {4'd9, O_BAD, W_DEC}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic pc_we, pc_we_cond, mem_rd, mem_wr, ir_we, rf_we, addr_is_data;
    logic dst_is_rd, wb_from_mem, alu_a_sel;
    logic [1:0] alu_b_sel, alu_class, pc_sel;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    mc_ctrl_fsm u_dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_we(pc_we), .pc_we_cond(pc_we_cond), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_we(ir_we), .rf_we(rf_we), .addr_is_data(addr_is_data),
        .dst_is_rd(dst_is_rd), .wb_from_mem(wb_from_mem), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_class(alu_class), .pc_sel(pc_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] word();
        return {pc_we, pc_we_cond, mem_rd, mem_wr, ir_we, rf_we, addr_is_data,
                dst_is_rd, wb_from_mem, alu_a_sel, alu_b_sel, alu_class, pc_sel};
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        n_checks++;
        if (word() !== exp) begin
            n_fail++;
            $display("FAIL %s: control word actual %h expected %h", req, word(), exp);
        end
        n_checks++;
        if (mem_rd && mem_wr) begin // R11
            n_fail++;
            $display("FAIL R11: mem_rd/mem_wr actual 1/1 expected not both");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: cycles actual 5000 expected fewer");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1 check("R1", 16'h0000);
        rst = 1'b0;
        #1 check("R1", W_FETCH);

        // main table: one row per cycle
        for (int i = 0; i < NVEC; i++) begin
            opcode = VEC[i][21:16];
            #1 check($sformatf("R%0d", VEC[i][25:22]), VEC[i][15:0]);
            @(negedge clk);
        end

        // R9: the unknown opcode is followed by a new fetch
        #1 check("R9", W_FETCH);

        // R10: opcode changes inside the fetch cycle do not move outputs
        opcode = 6'b111111;
        #1 check("R10", W_FETCH);
        opcode = O_BQ;
        #1 check("R10", W_FETCH);
        @(negedge clk);
        #1 check("R3", W_DEC);
        @(negedge clk);
        opcode = O_LW; // changed inside branch step
        #1 check("R10", W_BR);
        @(negedge clk);
        #1 check("R7", W_FETCH);

        // R1: reset asserted in the middle of a load
        opcode = O_LW;
        @(negedge clk);
        @(negedge clk);
        #1 check("R4", W_ADDR);
        rst = 1'b1;
        #1 check("R1", 16'h0000);
        @(negedge clk);
        #1 check("R1", 16'h0000);
        rst = 1'b0;
        #1 check("R1", W_FETCH);
        @(negedge clk);
        #1 check("R2", W_DEC);

        finish_run();
    end

endmodule